// File: doc/BRIEF.md
# Electronic Shutter Sweep Controller

This block sets the exposure time of a CCD sensor. It decides on which lines a charge-sweep pulse goes to the substrate and which readout strobes reach the sensor. Each sweep pulse throws away the charge gathered so far, so exposure is the time between the last sweep and the readout. The controller takes line and field start strobes, the externally generated readout strobe, a trigger input, an enable, a 2-bit mode, a 525/625-line select and a 9-bit load value. It drives a one-cycle sweep pulse and a gated copy of the readout strobe.

The four modes work as follows:
- **High-speed**: the load value sets the exposure as a count of lines at the end of the field.
- **Flickerless**: the exposure is fixed at one mains-light period.
- **Low-speed**: sweeping stops completely, and the readout is passed only once every programmed number of fields, so that charge builds up over several fields.
- **Off**: no sweeping, and every readout is passed.

A falling edge on the trigger input cuts exposure short. It blocks sweeping from that edge until the next readout strobe, which gives a continuously variable exposure.

Enable, mode, line standard and load value are captured only at a field start. A field therefore never runs with a half-applied setting.

Top module: `shutter_sweep_ctrl`

## Requirements
- R1: After reset both outputs are low and the captured setting is "off". Line strobes given before the first field strobe produce no sweep pulse.
- R2: When the captured enable is low, or the captured mode is off (mode code 2'b11), no sweep pulse is issued. Every readout strobe is passed: `readOut` goes high for one cycle, one clock after `readStrobe` is sampled.
- R3: In high-speed mode (code 2'b00) with load L, lines are numbered from 0 at the field strobe. A line with index below 511 − L gets one sweep pulse, two clocks after its line strobe is sampled. This gives an exposure of (lines per field) − (511 − L) lines. The 525-line field is 262 lines and the 625-line field is 312 lines.
- R4: In flickerless mode (code 2'b10), sweeping stops at line 105 on the 525-line standard (`pal`=0), leaving 157 lines. It stops at line 182 on the 625-line standard (`pal`=1), leaving 130 lines.
- R5: In low-speed mode (code 2'b01) with load L, no sweep pulse is issued. Counting fields from entry into the mode, a readout strobe is passed only in every M-th field, where M = 2 × (511 − L).
- R6: In low-speed mode, load value 0x1FF is invalid and is treated as off. There are no sweeps and every readout is passed.
- R7: In high-speed and flickerless modes, a falling edge on `trigIn` blocks sweep pulses from the next line decision until a readout strobe is seen. If a falling edge and a readout strobe arrive together, the falling edge wins.
- R8: With `trigIn` held high, the sweep pattern equals the programmed one from R3 or R4.
- R9: A change of `enable`, `mode`, `pal` or `loadVal` takes effect only at the next field strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineStrobe | input | 1 | One-cycle pulse at each line start |
| fieldStrobe | input | 1 | One-cycle pulse at field start; given together with the first line strobe |
| readStrobe | input | 1 | One-cycle readout request from the timing generator |
| trigIn | input | 1 | Exposure trigger; a falling edge opens the blocking window |
| enable | input | 1 | Shutter enable, captured at field start |
| pal | input | 1 | 0: 525-line timing, 1: 625-line timing |
| mode | input | 2 | 00 high-speed, 01 low-speed, 10 flickerless, 11 off |
| loadVal | input | 9 | Exposure load value |
| sweepPulse | output | 1 | Charge-sweep pulse, one cycle per swept line |
| readOut | output | 1 | Gated readout strobe to the sensor |

## Verification
Some rules are checked by the assertions on every cycle:
- a sweep pulse only ever follows a line strobe by two clocks, and a passed readout only ever follows a readout strobe by one clock;
- a field captured as off, low-speed or full-exposure never sweeps;
- a field captured as anything other than valid low-speed passes every readout.

Other behaviour can only be shown by the bench's scenarios against its cycle model and its per-field pulse counts. This covers the exact line where sweeping stops for each load value and line standard, the M-field readout pattern, the trigger window, and the deferred effect of a setting change made mid-field.

// File: rtl/shutter_pkg.sv
package shutter_pkg;

  typedef enum logic [1:0] {
    MODE_HIGH  = 2'b00,
    MODE_LOW   = 2'b01,
    MODE_FLICK = 2'b10,
    MODE_OFF   = 2'b11
  } shutMode_e;

  // Event strobes from the control side to the datapath.
  typedef struct packed {
    logic fieldStart;  // field boundary seen this cycle
    logic lineStart;   // line boundary seen this cycle
    logic decide;      // line boundary one cycle ago: take the sweep decision
    logic readNow;     // readout strobe this cycle
    logic hold;        // trigger window open
  } shutStrobe_t;

endpackage

// File: rtl/shutter_ctrl.sv
module shutter_ctrl
  import shutter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineStrobe,
  input  logic        fieldStrobe,
  input  logic        readStrobe,
  input  logic        trigIn,
  output shutStrobe_t strb
);

  logic trigQ;
  logic holdQ;
  logic lineQ;
  logic trigFall;

  assign trigFall = trigQ & ~trigIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigQ <= 1'b1;
      holdQ <= 1'b0;
      lineQ <= 1'b0;
    end else begin
      trigQ <= trigIn;
      lineQ <= lineStrobe;
      // a fresh falling edge outranks a coincident readout
      if (trigFall)
        holdQ <= 1'b1;
      else if (readStrobe)
        holdQ <= 1'b0;
    end
  end

  always_comb begin
    strb.fieldStart = fieldStrobe;
    strb.lineStart  = lineStrobe;
    strb.decide     = lineQ;
    strb.readNow    = readStrobe;
    strb.hold       = holdQ;
  end

endmodule

// File: rtl/shutter_dpath.sv
module shutter_dpath
  import shutter_pkg::*;
#(
  parameter int LOAD_W  = 9,
  parameter int LINES_A = 262,
  parameter int LINES_B = 312,
  parameter int FLICK_A = 157,
  parameter int FLICK_B = 130
) (
  input  logic              clk,
  input  logic              rstN,
  input  shutStrobe_t       strb,
  input  logic              enable,
  input  logic              pal,
  input  logic [1:0]        mode,
  input  logic [LOAD_W-1:0] loadVal,
  output logic              sweepPulse,
  output logic              readOut
);

  localparam int IDX_W         = LOAD_W + 1;
  localparam int FLICK_START_A = LINES_A - FLICK_A;
  localparam int FLICK_START_B = LINES_B - FLICK_B;

  // settings captured at field start
  logic              cfgEn;
  logic              cfgPal;
  shutMode_e         cfgMode;
  logic [LOAD_W-1:0] cfgLoad;

  logic [IDX_W-1:0]  lineIdx;
  logic [IDX_W-1:0]  fieldCnt;

  shutMode_e         effMode;
  logic [IDX_W-1:0]  startLine;
  logic [IDX_W-1:0]  lastField;
  logic              trigApplies;
  logic              allowSweep;
  logic              readGate;
  logic              fieldWrap;

  always_comb begin
    if (!cfgEn || (cfgMode == MODE_LOW && cfgLoad == '1))
      effMode = MODE_OFF;
    else
      effMode = cfgMode;
  end

  always_comb begin
    case (effMode)
      MODE_HIGH:  startLine = {1'b0, ~cfgLoad};
      MODE_FLICK: startLine = cfgPal ? IDX_W'(FLICK_START_B) : IDX_W'(FLICK_START_A);
      default:    startLine = '0;
    endcase
  end

  assign lastField   = {~cfgLoad, 1'b0} - IDX_W'(1);
  assign fieldWrap   = (fieldCnt >= lastField);
  assign trigApplies = (effMode == MODE_HIGH) || (effMode == MODE_FLICK);
  assign allowSweep  = (lineIdx < startLine) && !(strb.hold && trigApplies);
  assign readGate    = (effMode != MODE_LOW) || fieldWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn    <= 1'b0;
      cfgPal   <= 1'b0;
      cfgMode  <= MODE_OFF;
      cfgLoad  <= '0;
      lineIdx  <= '0;
      fieldCnt <= '0;
    end else if (strb.fieldStart) begin
      if (effMode == MODE_LOW)
        fieldCnt <= fieldWrap ? '0 : fieldCnt + IDX_W'(1);
      else
        fieldCnt <= '0;
      cfgEn   <= enable;
      cfgPal  <= pal;
      cfgMode <= shutMode_e'(mode);
      cfgLoad <= loadVal;
      lineIdx <= '0;
    end else if (strb.lineStart && lineIdx != '1) begin
      lineIdx <= lineIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sweepPulse <= 1'b0;
      readOut    <= 1'b0;
    end else begin
      sweepPulse <= strb.decide && allowSweep;
      readOut    <= strb.readNow && readGate;
    end
  end

endmodule

// File: rtl/shutter_sweep_ctrl.sv
module shutter_sweep_ctrl
  import shutter_pkg::*;
#(
  parameter int LOAD_W  = 9,
  parameter int LINES_A = 262,
  parameter int LINES_B = 312,
  parameter int FLICK_A = 157,
  parameter int FLICK_B = 130
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStrobe,
  input  logic              fieldStrobe,
  input  logic              readStrobe,
  input  logic              trigIn,
  input  logic              enable,
  input  logic              pal,
  input  logic [1:0]        mode,
  input  logic [LOAD_W-1:0] loadVal,
  output logic              sweepPulse,
  output logic              readOut
);

  shutStrobe_t strb;

  shutter_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lineStrobe  (lineStrobe),
    .fieldStrobe (fieldStrobe),
    .readStrobe  (readStrobe),
    .trigIn      (trigIn),
    .strb        (strb)
  );

  shutter_dpath #(
    .LOAD_W  (LOAD_W),
    .LINES_A (LINES_A),
    .LINES_B (LINES_B),
    .FLICK_A (FLICK_A),
    .FLICK_B (FLICK_B)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .enable     (enable),
    .pal        (pal),
    .mode       (mode),
    .loadVal    (loadVal),
    .sweepPulse (sweepPulse),
    .readOut    (readOut)
  );

endmodule

// File: rtl/shutter_sweep_chk.sv
module shutter_sweep_chk #(
  parameter int LOAD_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineStrobe,
  input logic              fieldStrobe,
  input logic              readStrobe,
  input logic              enable,
  input logic [1:0]        mode,
  input logic [LOAD_W-1:0] loadVal,
  input logic              sweepPulse,
  input logic              readOut
);

  // Settings seen at the last field strobe, in checker terms.
  logic shNoSweep;
  logic shPass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shNoSweep <= 1'b1;
      shPass    <= 1'b1;
    end else if (fieldStrobe) begin
      shNoSweep <= !enable || mode == 2'b11 || mode == 2'b01 ||
                   (mode == 2'b00 && loadVal == '1);
      shPass    <= !(enable && mode == 2'b01 && loadVal != '1);
    end
  end

  // R3
  sweep_after_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    sweepPulse |-> $past(lineStrobe, 2));

  // R2
  read_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    readOut |-> $past(readStrobe));

  // R5
  quiet_sweep_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(shNoSweep) |-> !sweepPulse);

  // R6
  read_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(readStrobe) && $past(shPass)) |-> readOut);

endmodule

bind shutter_sweep_ctrl shutter_sweep_chk #(.LOAD_W(LOAD_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .lineStrobe  (lineStrobe),
  .fieldStrobe (fieldStrobe),
  .readStrobe  (readStrobe),
  .enable      (enable),
  .mode        (mode),
  .loadVal     (loadVal),
  .sweepPulse  (sweepPulse),
  .readOut     (readOut)
);

// File: tb/shutter_sweep_ctrl_bench.sv
`timescale 1ns/1ps
module shutter_sweep_ctrl_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStrobe = 1'b0, fieldStrobe = 1'b0, readStrobe = 1'b0;
  logic trigIn = 1'b1, enable = 1'b0, pal = 1'b0;
  logic [1:0] mode = 2'b11;
  logic [8:0] loadVal = 9'h000;
  logic sweepPulse, readOut;

  always #10 clk = ~clk;  // 50 MHz

  shutter_sweep_ctrl u_shutter_sweep_ctrl (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .fieldStrobe(fieldStrobe),
    .readStrobe(readStrobe), .trigIn(trigIn), .enable(enable), .pal(pal),
    .mode(mode), .loadVal(loadVal), .sweepPulse(sweepPulse), .readOut(readOut)
  );

  int errors = 0;
  int checks = 0;
  string curTag = "R1";
  bit finished = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mIdx, mFcnt, cMode, cLoad;
  bit  mHold, mTrigPrev, mDec, cEn, cPal;
  bit  expSweep, expRead;

  function automatic int effOf(bit en, int md, int ld);
    if (!en || md == 3 || (md == 1 && ld == 511)) return 3;
    return md;
  endfunction

  function automatic int stopLine(int em, bit p, int ld);
    if (em == 0) return 511 - ld;
    if (em == 2) return p ? (312 - 130) : (262 - 157);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mIdx = 0; mFcnt = 0; mHold = 0; mTrigPrev = 1; mDec = 0;
      cEn = 0; cPal = 0; cMode = 3; cLoad = 0;
      expSweep = 0; expRead = 0;
    end else begin
      int em;
      int period;
      em = effOf(cEn, cMode, cLoad);
      period = 2 * (511 - cLoad);
      expSweep = mDec && (mIdx < stopLine(em, cPal, cLoad)) &&
                 !(mHold && (em == 0 || em == 2));
      expRead = readStrobe && (em != 1 || mFcnt >= period - 1);
      mDec = lineStrobe;
      if (mTrigPrev && !trigIn) mHold = 1;
      else if (readStrobe) mHold = 0;
      mTrigPrev = trigIn;
      if (fieldStrobe) begin
        if (em == 1) mFcnt = (mFcnt >= period - 1) ? 0 : mFcnt + 1;
        else mFcnt = 0;
        cEn = enable; cPal = pal; cMode = int'(mode); cLoad = int'(loadVal);
        mIdx = 0;
      end else if (lineStrobe && mIdx < 1023) begin
        mIdx++;
      end
    end
  end

  int cntSweep = 0, cntRead = 0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(curTag, "sweepPulse", int'(sweepPulse), int'(expSweep));
      check(curTag, "readOut", int'(readOut), int'(expRead));
      cntSweep += int'(sweepPulse);
      cntRead  += int'(readOut);
    end
  end

  // ---------------- stimulus ----------------
  int fieldSweeps, fieldReads;

  task automatic runField(input int nLines, input bit withField, input int trigDn,
                          input int trigUp, input int chgLine, input int chgLoad);
    int s0, r0;
    s0 = cntSweep; r0 = cntRead;
    for (int i = 0; i < nLines; i++) begin
      @(negedge clk); lineStrobe = 1; fieldStrobe = withField && (i == 0);
      @(negedge clk); lineStrobe = 0; fieldStrobe = 0;
      if (i == trigDn) trigIn = 0;
      if (i == trigUp) trigIn = 1;
      if (i == chgLine) loadVal = 9'(chgLoad);
      if (withField && i == nLines - 1) readStrobe = 1;
      @(negedge clk); readStrobe = 0;
      repeat (2) @(negedge clk);
    end
    fieldSweeps = cntSweep - s0;
    fieldReads  = cntRead - r0;
  endtask

  task automatic setCfg(input bit en, input bit p, input logic [1:0] md, input int ld);
    enable = en; pal = p; mode = md; loadVal = 9'(ld);
  endtask

  task automatic plainField(input string tag, input int lines, input int expS, input int expR);
    curTag = tag;
    runField(lines, 1, -1, -1, -1, 0);
    check(tag, "sweeps per field", fieldSweeps, expS);
    check(tag, "reads per field", fieldReads, expR);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1", "sweepPulse in reset", int'(sweepPulse), 0);
    check("R1", "readOut in reset", int'(readOut), 0);
    @(negedge clk); rstN = 1;
    // R1: captured setting is off until a field strobe
    setCfg(1, 0, 2'b00, 9'h0A0);
    curTag = "R1";
    runField(3, 0, -1, -1, -1, 0);
    check("R1", "sweeps before first field", fieldSweeps, 0);

    // R2: enable low, then mode off
    setCfg(0, 0, 2'b00, 9'h0FA);
    plainField("R2", 262, 0, 1);
    setCfg(1, 0, 2'b11, 9'h0FA);
    plainField("R2", 262, 0, 1);

    // R3 / R8: high-speed line counts, trigger held high
    setCfg(1, 0, 2'b00, 9'h0FA);
    plainField("R8", 262, 261, 1);
    setCfg(1, 0, 2'b00, 9'h196);
    plainField("R3", 262, 105, 1);
    setCfg(1, 0, 2'b00, 9'h0A0);
    plainField("R3", 262, 262, 1);
    setCfg(1, 0, 2'b00, 9'h1FF);
    plainField("R3", 262, 0, 1);
    setCfg(1, 1, 2'b00, 9'h149);
    plainField("R3", 312, 182, 1);

    // R4: flickerless on both standards
    setCfg(1, 0, 2'b10, 9'h000);
    plainField("R4", 262, 105, 1);
    setCfg(1, 1, 2'b10, 9'h1FF);
    plainField("R4", 312, 182, 1);

    // R5: low-speed, M = 2 then M = 4
    setCfg(1, 0, 2'b01, 9'h1FE);
    for (int k = 1; k <= 4; k++) plainField("R5", 262, 0, (k % 2 == 0) ? 1 : 0);
    setCfg(1, 0, 2'b01, 9'h1FD);
    for (int k = 1; k <= 4; k++) plainField("R5", 262, 0, (k % 4 == 0) ? 1 : 0);

    // R6: invalid low-speed load acts as off
    setCfg(1, 0, 2'b01, 9'h1FF);
    plainField("R6", 262, 0, 1);
    plainField("R6", 262, 0, 1);

    // R7: trigger window, high-speed then flickerless
    setCfg(1, 0, 2'b00, 9'h196);
    curTag = "R7";
    runField(262, 1, 50, 60, -1, 0);
    check("R7", "sweeps with trigger at line 50", fieldSweeps, 51);
    check("R7", "reads with trigger", fieldReads, 1);
    plainField("R8", 262, 105, 1);
    setCfg(1, 0, 2'b10, 9'h000);
    curTag = "R7";
    runField(262, 1, 20, 30, -1, 0);
    check("R7", "flickerless sweeps with trigger at line 20", fieldSweeps, 21);

    // R9: load change mid-field applies at the next field
    setCfg(1, 0, 2'b00, 9'h196);
    curTag = "R9";
    runField(262, 1, -1, -1, 10, 9'h0FA);
    check("R9", "sweeps in field of change", fieldSweeps, 105);
    plainField("R9", 262, 261, 1);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule